// File: doc/BRIEF.md
# Way-Banked L1 Data Port Arbiter

This block sits in front of an 8-way L1 data array whose storage is cut into 128 four-byte banks, sixteen per way. Each cycle up to three accesses arrive: two loads and one store. Each access carries a predicted way, a word index (address bits 5:2), a size code and a short line tag from the way predictor. The block works out which banks each access needs and finds which accesses collide. It grants or stalls each one and reports the colliding pairs. It does not hold data and does not predict ways.

Because banks are split by way as well as by word, two accesses to the same word in different ways never collide. A collision needs the same way, at least one shared bank and different line tags. When the line tag also matches, the two accesses read the same line and share the bank read. On a collision, load port 0 wins over load port 1, and load port 1 wins over the store. A losing access is stalled and the requester presents it again on a later cycle. An access that would run past the last bank of its line, or that carries a size code above 16 bytes, is faulted and never granted.

Each port has a small state machine with the states IDLE, GRANT, STALL and FAULT. All outputs come from registers, so a decision shows up one cycle after its inputs are sampled. Every cycle, each port moves to a new state chosen from its inputs alone. It goes to IDLE when the port is not valid. It goes to FAULT when the span is illegal. It goes to GRANT when no granted higher-priority access collides with it. It goes to STALL otherwise. Reset forces IDLE.

Top module: `way_bank_arbiter`

## Requirements
- R1: While reset is asserted, every grant, stall, fault, bank-enable and conflict output is zero.
- R2: A granted access enables global banks way*16+word through way*16+word+n-1. Here n is 1 for size codes 0, 1 and 2 (1, 2 and 4 bytes), 2 for code 3 (8 bytes) and 4 for code 4 (16 bytes). Outputs appear one clock edge after the inputs are sampled.
- R3: An access with word+n greater than 16, or with a size code of 5, 6 or 7, raises its fault output only. It gets no grant, no stall and no bank enables, and it takes no part in conflicts.
- R4: Accesses to different ways never conflict, even when their word ranges overlap.
- R5: Two live accesses conflict when they share a way, overlap in at least one bank and carry different line tags. The lower-priority one is stalled, with priority order load 0, load 1, store, and its bank enables are zero.
- R6: Two live accesses with the same way, overlapping banks and the same line tag do not conflict, and both are granted.
- R7: Load port 0 is never stalled.
- R8: An access stalls only because of a collision with an access that is granted. A store that collides only with a stalled load 1 is granted.
- R9: The conflict output flags raw collisions between live accesses, whether or not they are granted. Bit 0 is load 0 against load 1, bit 1 is load 0 against the store, and bit 2 is load 1 against the store.
- R10: A port whose valid input is low drives all its outputs to zero and never causes another port to stall.
- R11: A stalled access presented again after its winning rival has gone is granted on that retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ld0_valid_i | input | 1 | Load 0 request present |
| ld0_way_i | input | 3 | Load 0 predicted way |
| ld0_word_i | input | 4 | Load 0 starting word (address bits 5:2) |
| ld0_size_i | input | 3 | Load 0 size code (bytes = 2^code) |
| ld0_utag_i | input | 8 | Load 0 line tag |
| ld1_valid_i | input | 1 | Load 1 request present |
| ld1_way_i | input | 3 | Load 1 predicted way |
| ld1_word_i | input | 4 | Load 1 starting word |
| ld1_size_i | input | 3 | Load 1 size code |
| ld1_utag_i | input | 8 | Load 1 line tag |
| st_valid_i | input | 1 | Store request present |
| st_way_i | input | 3 | Store predicted way |
| st_word_i | input | 4 | Store starting word |
| st_size_i | input | 3 | Store size code |
| st_utag_i | input | 8 | Store line tag |
| ld0_grant_o | output | 1 | Load 0 granted |
| ld0_stall_o | output | 1 | Load 0 stalled |
| ld0_fault_o | output | 1 | Load 0 illegal span |
| ld0_banks_o | output | 128 | Load 0 bank enables |
| ld1_grant_o | output | 1 | Load 1 granted |
| ld1_stall_o | output | 1 | Load 1 stalled |
| ld1_fault_o | output | 1 | Load 1 illegal span |
| ld1_banks_o | output | 128 | Load 1 bank enables |
| st_grant_o | output | 1 | Store granted |
| st_stall_o | output | 1 | Store stalled |
| st_fault_o | output | 1 | Store illegal span |
| st_banks_o | output | 128 | Store bank enables |
| conflict_o | output | 3 | Raw pairwise collision flags |

## Verification
A wrong port state shows up on the very next cycle. A grant appears without bank enables, or a stall appears while the conflict flags are clear, or two granted accesses share a bank while carrying different line tags. A span decode error shows up as a bank vector wider than four bits or shifted to the wrong way. The same error reaches the arbitration as a missing or false conflict bit in that same cycle. A broken priority chain shows up as load 0 stalling, or as a store that stays stalled behind a load that was itself stalled.

// File: rtl/wba_pkg.sv
package wba_pkg;

    localparam int NPORTS = 3;
    localparam int SIZE_W = 3;

    localparam int PORT_LD0 = 0;
    localparam int PORT_LD1 = 1;
    localparam int PORT_ST  = 2;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_GRANT = 2'd1,
        PORT_STALL = 2'd2,
        PORT_FAULT = 2'd3
    } port_state_e;

endpackage

// File: rtl/wba_span_decode.sv
module wba_span_decode
    import wba_pkg::*;
#(
    parameter int WAYS          = 8,
    parameter int BANKS_PER_WAY = 16,
    parameter int BANK_BYTES    = 4,
    parameter int MAX_SPAN      = 4,
    localparam int WAY_W        = $clog2(WAYS),
    localparam int WORD_W       = $clog2(BANKS_PER_WAY),
    localparam int NUM_BANKS    = WAYS * BANKS_PER_WAY,
    localparam int MAX_CODE     = $clog2(MAX_SPAN * BANK_BYTES)
) (
    input  logic [WAY_W-1:0]     way_i,
    input  logic [WORD_W-1:0]    word_i,
    input  logic [SIZE_W-1:0]    size_i,
    output logic [NUM_BANKS-1:0] mask_o,
    output logic                 fault_o
);

    logic [BANKS_PER_WAY-1:0] row;
    logic                     bad_code;
    logic                     past_end;
    int                       nbanks;
    int                       first;

    // Bank count rounds the byte count up to whole banks; illegal spans clear the row.
    always_comb begin
        nbanks   = ((32'sd1 << size_i) + BANK_BYTES - 1) / BANK_BYTES;
        first    = int'(word_i);
        bad_code = int'(size_i) > MAX_CODE;
        past_end = (first + nbanks) > BANKS_PER_WAY;
        fault_o  = bad_code || past_end;
        for (int b = 0; b < BANKS_PER_WAY; b++) begin
            row[b] = !fault_o && (b >= first) && (b < first + nbanks);
        end
    end

    // Only the predicted way's slice of the global bank vector is populated.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign mask_o[w*BANKS_PER_WAY +: BANKS_PER_WAY] =
            (way_i == WAY_W'(w)) ? row : '0;
    end

endmodule

// File: rtl/wba_pair_conflict.sv
module wba_pair_conflict #(
    parameter int NUM_BANKS = 128,
    parameter int UTAG_W    = 8
) (
    input  logic                 a_live_i,
    input  logic [NUM_BANKS-1:0] a_mask_i,
    input  logic [UTAG_W-1:0]    a_utag_i,
    input  logic                 b_live_i,
    input  logic [NUM_BANKS-1:0] b_mask_i,
    input  logic [UTAG_W-1:0]    b_utag_i,
    output logic                 hit_o
);

    logic overlap;

    // Masks already carry the way, so any shared bit means same way and same bank.
    assign overlap = |(a_mask_i & b_mask_i);
    assign hit_o   = a_live_i && b_live_i && overlap && (a_utag_i != b_utag_i);

endmodule

// File: rtl/wba_port_stage.sv
module wba_port_stage
    import wba_pkg::*;
#(
    parameter int NUM_BANKS = 128
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 valid_i,
    input  logic                 fault_i,
    input  logic                 grant_i,
    input  logic [NUM_BANKS-1:0] mask_i,
    output logic                 grant_o,
    output logic                 stall_o,
    output logic                 fault_o,
    output logic [NUM_BANKS-1:0] banks_o
);

    port_state_e          state_d;
    port_state_e          state_q;
    logic [NUM_BANKS-1:0] banks_q;

    // Next state is chosen afresh every cycle from this cycle's request.
    always_comb begin
        if (!valid_i) begin
            state_d = PORT_IDLE;
        end else if (fault_i) begin
            state_d = PORT_FAULT;
        end else if (grant_i) begin
            state_d = PORT_GRANT;
        end else begin
            state_d = PORT_STALL;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= PORT_IDLE;
            banks_q <= '0;
        end else begin
            state_q <= state_d;
            banks_q <= (state_d == PORT_GRANT) ? mask_i : '0;
        end
    end

    always_comb begin
        grant_o = 1'b0;
        stall_o = 1'b0;
        fault_o = 1'b0;
        unique case (state_q)
            PORT_IDLE:  ;
            PORT_GRANT: grant_o = 1'b1;
            PORT_STALL: stall_o = 1'b1;
            PORT_FAULT: fault_o = 1'b1;
        endcase
    end

    assign banks_o = banks_q;

    // R2: a granted port always drives at least one bank, and others drive none.
    p_banks_iff_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o == (banks_o != '0));

    // R3: a faulted port drives no bank enables.
    p_fault_no_banks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (banks_o == '0));

endmodule

// File: rtl/way_bank_arbiter.sv
module way_bank_arbiter
    import wba_pkg::*;
#(
    parameter int WAYS          = 8,
    parameter int BANKS_PER_WAY = 16,
    parameter int BANK_BYTES    = 4,
    parameter int MAX_SPAN      = 4,
    parameter int UTAG_W        = 8,
    localparam int WAY_W        = $clog2(WAYS),
    localparam int WORD_W       = $clog2(BANKS_PER_WAY),
    localparam int NUM_BANKS    = WAYS * BANKS_PER_WAY
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 ld0_valid_i,
    input  logic [WAY_W-1:0]     ld0_way_i,
    input  logic [WORD_W-1:0]    ld0_word_i,
    input  logic [SIZE_W-1:0]    ld0_size_i,
    input  logic [UTAG_W-1:0]    ld0_utag_i,
    input  logic                 ld1_valid_i,
    input  logic [WAY_W-1:0]     ld1_way_i,
    input  logic [WORD_W-1:0]    ld1_word_i,
    input  logic [SIZE_W-1:0]    ld1_size_i,
    input  logic [UTAG_W-1:0]    ld1_utag_i,
    input  logic                 st_valid_i,
    input  logic [WAY_W-1:0]     st_way_i,
    input  logic [WORD_W-1:0]    st_word_i,
    input  logic [SIZE_W-1:0]    st_size_i,
    input  logic [UTAG_W-1:0]    st_utag_i,
    output logic                 ld0_grant_o,
    output logic                 ld0_stall_o,
    output logic                 ld0_fault_o,
    output logic [NUM_BANKS-1:0] ld0_banks_o,
    output logic                 ld1_grant_o,
    output logic                 ld1_stall_o,
    output logic                 ld1_fault_o,
    output logic [NUM_BANKS-1:0] ld1_banks_o,
    output logic                 st_grant_o,
    output logic                 st_stall_o,
    output logic                 st_fault_o,
    output logic [NUM_BANKS-1:0] st_banks_o,
    output logic [2:0]           conflict_o
);

    logic [NPORTS-1:0]                valid;
    logic [NPORTS-1:0][WAY_W-1:0]     way;
    logic [NPORTS-1:0][WORD_W-1:0]    word;
    logic [NPORTS-1:0][SIZE_W-1:0]    size;
    logic [NPORTS-1:0][UTAG_W-1:0]    utag;
    logic [NPORTS-1:0][NUM_BANKS-1:0] mask;
    logic [NPORTS-1:0][NUM_BANKS-1:0] banks_q;
    logic [NPORTS-1:0]                fault;
    logic [NPORTS-1:0]                live;
    logic [NPORTS-1:0]                grant;
    logic [NPORTS-1:0]                gnt_q;
    logic [NPORTS-1:0]                stl_q;
    logic [NPORTS-1:0]                flt_q;
    logic                             hit_01;
    logic                             hit_02;
    logic                             hit_12;
    logic [2:0]                       conflict_q;

    assign valid = {st_valid_i, ld1_valid_i, ld0_valid_i};
    assign way   = {st_way_i,   ld1_way_i,   ld0_way_i};
    assign word  = {st_word_i,  ld1_word_i,  ld0_word_i};
    assign size  = {st_size_i,  ld1_size_i,  ld0_size_i};
    assign utag  = {st_utag_i,  ld1_utag_i,  ld0_utag_i};

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        wba_span_decode #(
            .WAYS          (WAYS),
            .BANKS_PER_WAY (BANKS_PER_WAY),
            .BANK_BYTES    (BANK_BYTES),
            .MAX_SPAN      (MAX_SPAN)
        ) u_span (
            .way_i   (way[p]),
            .word_i  (word[p]),
            .size_i  (size[p]),
            .mask_o  (mask[p]),
            .fault_o (fault[p])
        );

        wba_port_stage #(
            .NUM_BANKS (NUM_BANKS)
        ) u_stage (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .valid_i (valid[p]),
            .fault_i (fault[p]),
            .grant_i (grant[p]),
            .mask_i  (mask[p]),
            .grant_o (gnt_q[p]),
            .stall_o (stl_q[p]),
            .fault_o (flt_q[p]),
            .banks_o (banks_q[p])
        );

        // R2: no granted access spans more than MAX_SPAN banks.
        p_span_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $countones(banks_q[p]) <= MAX_SPAN);

        // R10: an absent request leaves the port quiet on the next cycle.
        p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !valid[p] |=> (!gnt_q[p] && !stl_q[p] && !flt_q[p] && banks_q[p] == '0));

        // R3: a port holds at most one outcome.
        p_one_outcome_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0({gnt_q[p], stl_q[p], flt_q[p]}));
    end

    assign live = valid & ~fault;

    wba_pair_conflict #(.NUM_BANKS(NUM_BANKS), .UTAG_W(UTAG_W)) u_pair_01 (
        .a_live_i (live[PORT_LD0]), .a_mask_i (mask[PORT_LD0]), .a_utag_i (utag[PORT_LD0]),
        .b_live_i (live[PORT_LD1]), .b_mask_i (mask[PORT_LD1]), .b_utag_i (utag[PORT_LD1]),
        .hit_o    (hit_01)
    );

    wba_pair_conflict #(.NUM_BANKS(NUM_BANKS), .UTAG_W(UTAG_W)) u_pair_02 (
        .a_live_i (live[PORT_LD0]), .a_mask_i (mask[PORT_LD0]), .a_utag_i (utag[PORT_LD0]),
        .b_live_i (live[PORT_ST]),  .b_mask_i (mask[PORT_ST]),  .b_utag_i (utag[PORT_ST]),
        .hit_o    (hit_02)
    );

    wba_pair_conflict #(.NUM_BANKS(NUM_BANKS), .UTAG_W(UTAG_W)) u_pair_12 (
        .a_live_i (live[PORT_LD1]), .a_mask_i (mask[PORT_LD1]), .a_utag_i (utag[PORT_LD1]),
        .b_live_i (live[PORT_ST]),  .b_mask_i (mask[PORT_ST]),  .b_utag_i (utag[PORT_ST]),
        .hit_o    (hit_12)
    );

    // Priority chain: a port yields only to a higher-priority port that is itself granted.
    always_comb begin
        grant[PORT_LD0] = live[PORT_LD0];
        grant[PORT_LD1] = live[PORT_LD1] && !(hit_01 && grant[PORT_LD0]);
        grant[PORT_ST]  = live[PORT_ST]
                          && !(hit_02 && grant[PORT_LD0])
                          && !(hit_12 && grant[PORT_LD1]);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            conflict_q <= '0;
        end else begin
            conflict_q <= {hit_12, hit_02, hit_01};
        end
    end

    assign ld0_grant_o = gnt_q[PORT_LD0];
    assign ld0_stall_o = stl_q[PORT_LD0];
    assign ld0_fault_o = flt_q[PORT_LD0];
    assign ld0_banks_o = banks_q[PORT_LD0];
    assign ld1_grant_o = gnt_q[PORT_LD1];
    assign ld1_stall_o = stl_q[PORT_LD1];
    assign ld1_fault_o = flt_q[PORT_LD1];
    assign ld1_banks_o = banks_q[PORT_LD1];
    assign st_grant_o  = gnt_q[PORT_ST];
    assign st_stall_o  = stl_q[PORT_ST];
    assign st_fault_o  = flt_q[PORT_ST];
    assign st_banks_o  = banks_q[PORT_ST];
    assign conflict_o  = conflict_q;

    // R7: load port 0 never loses arbitration.
    p_ld0_never_stalls_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld0_stall_o);

    // R5: a stall always coincides with a reported collision for that port.
    p_ld1_stall_has_rival_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld1_stall_o |-> conflict_q[0]);
    p_st_stall_has_rival_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_stall_o |-> (conflict_q[1] || conflict_q[2]));

    // R6: granted accesses that share a bank must target the same line.
    p_shared_01_same_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld0_grant_o && ld1_grant_o && |(ld0_banks_o & ld1_banks_o))
        |-> ($past(ld0_utag_i) == $past(ld1_utag_i)));
    p_shared_02_same_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld0_grant_o && st_grant_o && |(ld0_banks_o & st_banks_o))
        |-> ($past(ld0_utag_i) == $past(st_utag_i)));
    p_shared_12_same_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld1_grant_o && st_grant_o && |(ld1_banks_o & st_banks_o))
        |-> ($past(ld1_utag_i) == $past(st_utag_i)));

endmodule

// File: tb/way_bank_arbiter_bench.sv
module way_bank_arbiter_bench;

    typedef struct packed {
        logic       v;
        logic [2:0] way;
        logic [3:0] word;
        logic [2:0] size;
        logic [7:0] utag;
    } port_t;

    // Bit order of g/s/f/c: bit0 = load 0, bit1 = load 1, bit2 = store (c: R9 pair order).
    typedef struct packed {
        logic [3:0] req;
        port_t      l0;
        port_t      l1;
        port_t      st;
        logic [2:0] g;
        logic [2:0] s;
        logic [2:0] f;
        logic [2:0] c;
    } vec_t;

    localparam port_t P0 = '0;
    localparam int NV = 12;

    localparam vec_t VECS [NV] = '{
        // R2: single 4-byte load, way 0 word 0
        '{4'd2,  '{1'b1,3'd0,4'd0,3'd2,8'hA1},  P0, P0, 3'b001,3'b000,3'b000,3'b000},
        // R5: same way, shared bank 6, different tags -> load 1 stalls
        '{4'd5,  '{1'b1,3'd3,4'd5,3'd3,8'hA1}, '{1'b1,3'd3,4'd6,3'd2,8'hB2}, P0, 3'b001,3'b010,3'b000,3'b001},
        // R6: same banks and same tag -> shared, both granted
        '{4'd6,  '{1'b1,3'd3,4'd5,3'd3,8'hA1}, '{1'b1,3'd3,4'd6,3'd2,8'hA1}, P0, 3'b011,3'b000,3'b000,3'b000},
        // R4: same word in three different ways
        '{4'd4,  '{1'b1,3'd1,4'd4,3'd4,8'hA1}, '{1'b1,3'd2,4'd4,3'd4,8'hB2}, '{1'b1,3'd3,4'd4,3'd4,8'hC3}, 3'b111,3'b000,3'b000,3'b000},
        // R3: load 0 runs past word 15, load 1 ends exactly at word 15
        '{4'd3,  '{1'b1,3'd0,4'd14,3'd4,8'hA1}, '{1'b1,3'd0,4'd14,3'd3,8'hB2}, P0, 3'b010,3'b000,3'b001,3'b000},
        // R3: store with size code 5
        '{4'd3,  '{1'b1,3'd0,4'd0,3'd2,8'hA1}, P0, '{1'b1,3'd0,4'd8,3'd5,8'hC3}, 3'b001,3'b000,3'b100,3'b000},
        // R8: store collides only with stalled load 1 -> store granted
        '{4'd8,  '{1'b1,3'd5,4'd0,3'd3,8'hA1}, '{1'b1,3'd5,4'd1,3'd3,8'hB2}, '{1'b1,3'd5,4'd2,3'd2,8'hC3}, 3'b101,3'b010,3'b000,3'b101},
        // R5: three-way collision on one bank, priority order
        '{4'd5,  '{1'b1,3'd7,4'd9,3'd2,8'hA1}, '{1'b1,3'd7,4'd9,3'd2,8'hB2}, '{1'b1,3'd7,4'd9,3'd2,8'hC3}, 3'b001,3'b110,3'b000,3'b111},
        // R5: load 1 beats the store with load 0 absent
        '{4'd5,  P0, '{1'b1,3'd2,4'd0,3'd4,8'hA1}, '{1'b1,3'd2,4'd3,3'd2,8'hB2}, 3'b010,3'b100,3'b000,3'b100},
        // R10: invalid load 1 with colliding fields has no effect
        '{4'd10, '{1'b1,3'd4,4'd0,3'd4,8'hA1}, '{1'b0,3'd4,4'd0,3'd4,8'hB2}, '{1'b1,3'd6,4'd0,3'd4,8'hC3}, 3'b101,3'b000,3'b000,3'b000},
        // R2: byte at word 15 and a 16-byte store ending at word 15 collide
        '{4'd2,  '{1'b1,3'd7,4'd15,3'd0,8'hA1}, P0, '{1'b1,3'd7,4'd12,3'd4,8'hC3}, 3'b001,3'b100,3'b000,3'b010},
        // R9: store shares load 0 line, load 1 collides with load 0 only
        '{4'd9,  '{1'b1,3'd2,4'd0,3'd4,8'hA1}, '{1'b1,3'd2,4'd2,3'd3,8'hB2}, '{1'b1,3'd2,4'd1,3'd2,8'hA1}, 3'b101,3'b010,3'b000,3'b001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       ld0_valid, ld1_valid, st_valid;
    logic [2:0] ld0_way, ld1_way, st_way;
    logic [3:0] ld0_word, ld1_word, st_word;
    logic [2:0] ld0_size, ld1_size, st_size;
    logic [7:0] ld0_utag, ld1_utag, st_utag;
    logic         ld0_grant, ld0_stall, ld0_fault;
    logic         ld1_grant, ld1_stall, ld1_fault;
    logic         st_grant, st_stall, st_fault;
    logic [127:0] ld0_banks, ld1_banks, st_banks;
    logic [2:0]   conflict;

    int checks = 0;
    int errors = 0;

    way_bank_arbiter u_way_bank_arbiter (
        .clk_i (clk), .rst_ni (rst_n),
        .ld0_valid_i (ld0_valid), .ld0_way_i (ld0_way), .ld0_word_i (ld0_word),
        .ld0_size_i (ld0_size), .ld0_utag_i (ld0_utag),
        .ld1_valid_i (ld1_valid), .ld1_way_i (ld1_way), .ld1_word_i (ld1_word),
        .ld1_size_i (ld1_size), .ld1_utag_i (ld1_utag),
        .st_valid_i (st_valid), .st_way_i (st_way), .st_word_i (st_word),
        .st_size_i (st_size), .st_utag_i (st_utag),
        .ld0_grant_o (ld0_grant), .ld0_stall_o (ld0_stall), .ld0_fault_o (ld0_fault),
        .ld0_banks_o (ld0_banks),
        .ld1_grant_o (ld1_grant), .ld1_stall_o (ld1_stall), .ld1_fault_o (ld1_fault),
        .ld1_banks_o (ld1_banks),
        .st_grant_o (st_grant), .st_stall_o (st_stall), .st_fault_o (st_fault),
        .st_banks_o (st_banks),
        .conflict_o (conflict)
    );

    task automatic drive(input port_t a, input port_t b, input port_t c);
        ld0_valid = a.v; ld0_way = a.way; ld0_word = a.word; ld0_size = a.size; ld0_utag = a.utag;
        ld1_valid = b.v; ld1_way = b.way; ld1_word = b.word; ld1_size = b.size; ld1_utag = b.utag;
        st_valid  = c.v; st_way  = c.way; st_word  = c.word; st_size  = c.size; st_utag  = c.utag;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected bank vector straight from the R2 mapping rule.
    function automatic logic [127:0] span_of(input port_t p);
        int n;
        logic [127:0] m;
        n = (p.size == 3'd3) ? 2 : (p.size == 3'd4) ? 4 : 1;
        m = '0;
        for (int i = 0; i < n; i++) m[int'(p.way)*16 + int'(p.word) + i] = 1'b1;
        return m;
    endfunction

    task automatic check_all(input string tag, input port_t a, input port_t b, input port_t c,
                             input logic [2:0] g, input logic [2:0] s,
                             input logic [2:0] f, input logic [2:0] cf);
        chk(tag, "grant",    128'({st_grant, ld1_grant, ld0_grant}), 128'(g));
        chk(tag, "stall",    128'({st_stall, ld1_stall, ld0_stall}), 128'(s));
        chk(tag, "fault",    128'({st_fault, ld1_fault, ld0_fault}), 128'(f));
        chk(tag, "conflict", 128'(conflict), 128'(cf));
        chk(tag, "ld0 banks", ld0_banks, g[0] ? span_of(a) : '0);
        chk(tag, "ld1 banks", ld1_banks, g[1] ? span_of(b) : '0);
        chk(tag, "st banks",  st_banks,  g[2] ? span_of(c) : '0);
    endtask

    localparam port_t QA = '{1'b1,3'd7,4'd9,3'd2,8'hA1};
    localparam port_t QB = '{1'b1,3'd7,4'd9,3'd2,8'hB2};
    localparam port_t QC = '{1'b1,3'd7,4'd9,3'd2,8'hC3};

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: requests present while in reset produce nothing
        drive(QA, QB, QC);
        repeat (3) @(negedge clk);
        check_all("R1", P0, P0, P0, 3'b000, 3'b000, 3'b000, 3'b000);
        rst_n = 1'b1;
        drive(P0, P0, P0);
        @(negedge clk);
        // R10: all ports idle
        check_all("R10", P0, P0, P0, 3'b000, 3'b000, 3'b000, 3'b000);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            drive(v.l0, v.l1, v.st);
            @(negedge clk);
            check_all($sformatf("R%0d vec%0d", v.req, i), v.l0, v.l1, v.st, v.g, v.s, v.f, v.c);
        end

        // R11: retry sequence after a three-way collision
        drive(QA, QB, QC);
        @(negedge clk);
        check_all("R11 step0", QA, QB, QC, 3'b001, 3'b110, 3'b000, 3'b111);
        drive(P0, QB, QC);
        @(negedge clk);
        check_all("R11 step1", P0, QB, QC, 3'b010, 3'b100, 3'b000, 3'b100);
        drive(P0, P0, QC);
        @(negedge clk);
        check_all("R11 step2", P0, P0, QC, 3'b100, 3'b000, 3'b000, 3'b000);
        chk("R2", "store bank 121", 128'(st_banks[121]), 128'(1));

        // R2: outputs hold until the next edge samples new inputs
        drive(P0, P0, P0);
        #2;
        chk("R2", "latency hold", 128'(st_grant), 128'(1));
        @(negedge clk);
        check_all("R10 idle", P0, P0, P0, 3'b000, 3'b000, 3'b000, 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule